// File: doc/BRIEF.md
# LED Driver Configuration Sequencer

This block programs the two control registers of a chain of constant-current LED driver chips on a parallel-row matrix panel, using only the panel's normal pins. A single start pulse launches a fixed sequence. The block blanks the display, shifts a 16-bit configuration word along the whole row so that every cascaded chip receives the same word, and then selects the destination register. The destination is chosen by how many of the final shift clocks the latch line is held high. After both writes it clears the data path, enables the outputs and raises `done`.

Two driver families are supported, selected by `fam_b_sel` when start is accepted. Each family has its own register words, its own clearing rows and its own latch rules. Family B also raises a flag that tells the downstream pixel engine to clock on the positive edge. The shift clock is derived from the system clock. Each shift clock has a low phase and a high phase, and each phase lasts `half_div + 1` system cycles.

Top module: `led_cfg_seq`

## Requirements
- R1: After reset, `sh_clk`, `latch`, `col_data`, `done` and `pos_edge_mode` are low and `out_en_n` is high.
- R2: Every shift clock is a low phase followed by a high phase, and each phase lasts exactly `half_div + 1` system cycles. `col_data` and `latch` change only while `sh_clk` is low.
- R3: All six colour data lines carry the same value at every shift clock.
- R4: A register write is one row of COLS shift clocks, where shift clock c carries bit (c mod 16) of the word in shift order. The family A words are 0000011111100000 for register 1 and 0000000001000000 for register 2, written first-sent first.
- R5: For a register-1 write, `latch` is high on the final 11 shift clocks of the row and low on the others. For a register-2 write it is high on the final 12.
- R6: Family A runs register 1, then register 2, then one row of zeros with `latch` low. One clock with `latch` high follows, then one clock with `latch` low and `out_en_n` low. The total is 3*COLS+2 clocks.
- R7: Family B runs a zero row with `latch` high on its final 3 clocks. Register 1 follows with 0x00FF sent most significant bit first, then register 2 with 0xFF00 sent the same way. One clock with `latch` and data low follows, then a second zero row with the same 3-clock latch, then one clock with `out_en_n` low. The total is 4*COLS+2 clocks.
- R8: `out_en_n` is high from an accepted start until the final clock of the sequence. It falls only while `sh_clk` and `latch` are low, before that final clock's high phase.
- R9: `done` rises in the same cycle that the final high phase ends. It stays high, with `sh_clk`, `latch` and data low and `out_en_n` low, until a new start is accepted. It drops one cycle after that start.
- R10: `pos_edge_mode` equals the family selected at the accepted start (1 for family B) and holds that value through and after the sequence.
- R11: A start pulse while a sequence is running, or a change of `fam_b_sel` during it, has no effect on the clocks, data, latch or final flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the sequence (accepted when idle or done) |
| fam_b_sel | input | 1 | 0 selects family A, 1 selects family B |
| half_div | input | DIV_W | Shift clock phase length minus one, in system cycles |
| col_data | output | 6 | Colour data lines (upper/lower R, G, B) |
| sh_clk | output | 1 | Panel shift clock |
| latch | output | 1 | Panel latch |
| out_en_n | output | 1 | Panel output enable, active low |
| done | output | 1 | Sequence complete |
| pos_edge_mode | output | 1 | Pixel data to be clocked on the positive edge |

## Verification
A wrong column count or segment transition appears at once as a shifted latch window or a misplaced word bit. The sign is a latch that rises one clock early or late within the row, and the total clock count at `done` also comes out wrong. A divider fault shows on the next phase as a wrong phase length. A lost family bit shows in the first row, because family B starts with a zero row and family A starts with register data, and it also shows in `pos_edge_mode` at the end. The bench records every rising shift clock against a computed list of expected data, latch and enable values, and it times every phase.

// File: rtl/led_cfg_pkg.sv
package led_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_WR1,
    ST_WR2,
    ST_BLANK,
    ST_FLAT,
    ST_ENABLE,
    ST_DONE
  } seq_state_e;

  localparam int LANES    = 6;
  localparam int WORD_W   = 16;
  localparam int IDX_W    = $clog2(WORD_W);

  // Column-order words: bit i leaves on column (i mod 16)
  localparam logic [WORD_W-1:0] A_REG1 = 16'h07E0;
  localparam logic [WORD_W-1:0] A_REG2 = 16'h0200;
  localparam logic [WORD_W-1:0] B_REG1 = 16'hFF00;
  localparam logic [WORD_W-1:0] B_REG2 = 16'h00FF;

  // Trailing latch lengths that pick the destination register
  localparam int LAT_REG1 = 11;
  localparam int LAT_REG2 = 12;
  localparam int LAT_CLR  = 3;

  function automatic logic seq_running(seq_state_e s);
    return (s != ST_IDLE) && (s != ST_DONE);
  endfunction

  function automatic logic seq_single(seq_state_e s);
    return (s == ST_FLAT) || (s == ST_ENABLE);
  endfunction

  function automatic seq_state_e seq_next(seq_state_e s, logic fam_b);
    seq_state_e n;
    case (s)
      ST_CLEAR:  n = ST_WR1;
      ST_WR1:    n = ST_WR2;
      ST_WR2:    n = fam_b ? ST_FLAT : ST_BLANK;
      ST_BLANK:  n = fam_b ? ST_ENABLE : ST_FLAT;
      ST_FLAT:   n = fam_b ? ST_BLANK : ST_ENABLE;
      ST_ENABLE: n = ST_DONE;
      default:   n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/led_cfg_div.sv
module led_cfg_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    tick   = run && (cnt_q == '0);
    cnt_en = load || run;
    if (load || tick) begin
      cnt_d = half_div;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (half_div != '0)) |=> !tick); // R2

endmodule

// File: rtl/led_cfg_ctrl.sv
module led_cfg_ctrl
  import led_cfg_pkg::*;
#(
  parameter int COLS = 64,
  localparam int CW  = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fam_b_in,
  input  logic          tick,
  output seq_state_e    state,
  output logic [CW-1:0] col,
  output logic          phase,
  output logic          fam_b,
  output logic          load,
  output logic          run
);

  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] col_q, col_d;
  logic          ph_q, ph_d;
  logic          fam_q, fam_d;
  logic          adv_en;
  logic          seg_end;

  always_comb begin
    run     = seq_running(state_q);
    load    = start && !run;
    adv_en  = load || (tick && run);
    seg_end = seq_single(state_q) || (col_q == COL_LAST);
    state_d = state_q;
    col_d   = col_q;
    ph_d    = ph_q;
    fam_d   = fam_q;
    if (load) begin
      state_d = fam_b_in ? ST_CLEAR : ST_WR1;
      col_d   = '0;
      ph_d    = 1'b0;
      fam_d   = fam_b_in;
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d = 1'b0;
      if (seg_end) begin
        col_d   = '0;
        state_d = seq_next(state_q, fam_q);
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      ph_q    <= 1'b0;
      fam_q   <= 1'b0;
    end else if (adv_en) begin
      state_q <= state_d;
      col_q   <= col_d;
      ph_q    <= ph_d;
      fam_q   <= fam_d;
    end
  end

  assign state = state_q;
  assign col   = col_q;
  assign phase = ph_q;
  assign fam_b = fam_q;

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_LAST); // R4

  AST_FAM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(fam_q)); // R11

endmodule

// File: rtl/led_cfg_pins.sv
module led_cfg_pins
  import led_cfg_pkg::*;
#(
  parameter int COLS = 64,
  localparam int CW  = $clog2(COLS)
) (
  input  seq_state_e       state,
  input  logic [CW-1:0]    col,
  input  logic             phase,
  input  logic             fam_b,
  output logic [LANES-1:0] col_data,
  output logic             sh_clk,
  output logic             latch,
  output logic             out_en_n,
  output logic             done
);

  localparam logic [CW-1:0] L1_FROM = CW'(COLS - LAT_REG1);
  localparam logic [CW-1:0] L2_FROM = CW'(COLS - LAT_REG2);
  localparam logic [CW-1:0] LZ_FROM = CW'(COLS - LAT_CLR);

  logic [IDX_W-1:0] widx;
  logic             bit_v;
  logic             lat_v;

  assign widx = col[IDX_W-1:0];

  always_comb begin
    bit_v = 1'b0;
    lat_v = 1'b0;
    case (state)
      ST_CLEAR: lat_v = (col >= LZ_FROM);
      ST_WR1: begin
        bit_v = fam_b ? B_REG1[widx] : A_REG1[widx];
        lat_v = (col >= L1_FROM);
      end
      ST_WR2: begin
        bit_v = fam_b ? B_REG2[widx] : A_REG2[widx];
        lat_v = (col >= L2_FROM);
      end
      ST_BLANK: lat_v = fam_b && (col >= LZ_FROM);
      ST_FLAT:  lat_v = !fam_b;
      default: begin
        bit_v = 1'b0;
        lat_v = 1'b0;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign col_data[g] = bit_v;
  end

  assign sh_clk   = phase && seq_running(state);
  assign latch    = lat_v;
  assign out_en_n = !((state == ST_ENABLE) || (state == ST_DONE));
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/led_cfg_seq.sv
module led_cfg_seq
  import led_cfg_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int DIV_W = 8,
  localparam int CW   = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fam_b_sel,
  input  logic [DIV_W-1:0] half_div,
  output logic [5:0]       col_data,
  output logic             sh_clk,
  output logic             latch,
  output logic             out_en_n,
  output logic             done,
  output logic             pos_edge_mode
);

  seq_state_e    state;
  logic [CW-1:0] col;
  logic          phase;
  logic          fam_b;
  logic          load;
  logic          run;
  logic          tick;

  led_cfg_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .run      (run),
    .half_div (half_div),
    .tick     (tick)
  );

  led_cfg_ctrl #(.COLS(COLS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .fam_b_in (fam_b_sel),
    .tick     (tick),
    .state    (state),
    .col      (col),
    .phase    (phase),
    .fam_b    (fam_b),
    .load     (load),
    .run      (run)
  );

  led_cfg_pins #(.COLS(COLS)) u_pins (
    .state    (state),
    .col      (col),
    .phase    (phase),
    .fam_b    (fam_b),
    .col_data (col_data),
    .sh_clk   (sh_clk),
    .latch    (latch),
    .out_en_n (out_en_n),
    .done     (done)
  );

  assign pos_edge_mode = fam_b;

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sh_clk |-> ($stable(col_data) && $stable(latch))); // R2

  AST_OE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en_n) |-> (!sh_clk && !latch)); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sh_clk && !latch && (col_data == '0) && !out_en_n)); // R9

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start && done) |=> (!done && out_en_n)); // R9

endmodule

// File: tb/sim_led_cfg_seq.sv
module sim_led_cfg_seq;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 32;
  localparam int DW         = 4;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          fam_b_sel;
  logic [DW-1:0] half_div;
  logic [5:0]    col_data;
  logic          sh_clk;
  logic          latch;
  logic          out_en_n;
  logic          done;
  logic          pos_edge_mode;

  led_cfg_seq #(.COLS(N), .DIV_W(DW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .fam_b_sel     (fam_b_sel),
    .half_div      (half_div),
    .col_data      (col_data),
    .sh_clk        (sh_clk),
    .latch         (latch),
    .out_en_n      (out_en_n),
    .done          (done),
    .pos_edge_mode (pos_edge_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int t_chk = 0, t_err = 0;
  int m_chk = 0, m_err = 0;

  // Expected {data bit, latch, out_en_n} for rising clock idx
  function automatic logic [2:0] exp_pulse(input logic fb, input int idx);
    int c;
    logic b, l, o;
    b = 1'b0; l = 1'b0; o = 1'b1;
    c = idx % N;
    if (!fb) begin
      if (idx < N) begin
        b = ((c % 16) >= 5) && ((c % 16) <= 10); l = (c >= N - 11);
      end else if (idx < 2*N) begin
        b = ((c % 16) == 9); l = (c >= N - 12);
      end else if (idx == 3*N) begin
        l = 1'b1;
      end else if (idx == 3*N + 1) begin
        o = 1'b0;
      end
    end else begin
      if (idx < N) begin
        l = (c >= N - 3);
      end else if (idx < 2*N) begin
        b = ((c % 16) >= 8); l = (c >= N - 11);
      end else if (idx < 3*N) begin
        b = ((c % 16) < 8); l = (c >= N - 12);
      end else if (idx > 3*N && idx <= 4*N) begin
        l = ((idx - 3*N - 1) >= N - 3);
      end else if (idx == 4*N + 1) begin
        o = 1'b0;
      end
    end
    return {b, l, o};
  endfunction

  function automatic string seg_tag(input logic fb, input int idx);
    if (!fb && idx < 2*N) return "R4 R5";
    if (fb && idx >= N && idx < 3*N) return "R4 R5";
    return fb ? "R7" : "R6";
  endfunction

  // Port monitor, sampled on the falling system edge
  logic       busy_m = 1'b0;
  logic       run_fam = 1'b0;
  logic [DW-1:0] run_div = '0;
  int         pulse_n = 0;
  int         len = 0;
  logic       p_s = 1'b0, p_l = 1'b0, p_d = 1'b0;
  logic [5:0] p_dat = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      busy_m = 1'b0;
    end else if (start && !busy_m) begin
      busy_m  = 1'b1;
      run_fam = fam_b_sel;
      run_div = half_div;
      pulse_n = 0;
      len     = 0;
    end else if (busy_m) begin
      if (sh_clk == p_s) begin
        len++;
        if (sh_clk && (col_data != p_dat || latch != p_l)) begin
          m_chk++; m_err++;
          $display("FAIL R2: data/latch moved while clock high, data=%h latch=%b expected data=%h latch=%b",
                   col_data, latch, p_dat, p_l);
        end
      end else begin
        m_chk++;
        if (len != int'(run_div) + 1) begin
          m_err++;
          $display("FAIL R2: phase length %0d expected %0d", len, int'(run_div) + 1);
        end
        len = 1;
        if (sh_clk) begin
          logic [2:0] e;
          e = exp_pulse(run_fam, pulse_n);
          m_chk++;
          if (col_data != 6'h00 && col_data != 6'h3F) begin
            m_err++;
            $display("FAIL R3: lanes differ, got %h expected 00 or 3f", col_data);
          end
          m_chk++;
          if (col_data[0] != e[2] || latch != e[1]) begin
            m_err++;
            $display("FAIL %s: clock %0d fam %0b got data=%b latch=%b expected data=%b latch=%b",
                     seg_tag(run_fam, pulse_n), pulse_n, run_fam, col_data[0], latch, e[2], e[1]);
          end
          m_chk++;
          if (out_en_n != e[0]) begin
            m_err++;
            $display("FAIL R8: clock %0d out_en_n=%b expected %b", pulse_n, out_en_n, e[0]);
          end
          pulse_n++;
        end
      end
      if (done && !p_d) begin
        m_chk++;
        if (!(p_s && !sh_clk) || pulse_n != (run_fam ? 4*N+2 : 3*N+2)) begin
          m_err++;
          $display("FAIL %s R9: done after %0d clocks (clk fell=%b) expected %0d",
                   run_fam ? "R7" : "R6", pulse_n, p_s && !sh_clk, run_fam ? 4*N+2 : 3*N+2);
        end
        busy_m = 1'b0;
      end
    end
    p_s = sh_clk; p_l = latch; p_d = done; p_dat = col_data;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    t_chk++;
    if (got !== exp) begin
      t_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic run_seq(input logic fb, input logic [DW-1:0] dv, input int poke_at);
    int w;
    @(posedge clk); #1;
    fam_b_sel = fb; half_div = dv; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    check("R8 R9 start clears done, blanks", {done, out_en_n, sh_clk}, 3'b010);
    if (poke_at > 0) begin
      repeat (poke_at) @(posedge clk);
      #1; start = 1'b1; fam_b_sel = ~fb;   // R11 poke while running
      @(posedge clk); #1; start = 1'b0;
    end
    w = 0;
    while (!done && w < 20000) begin
      @(posedge clk); w++;
    end
    @(negedge clk);
    check("R9 done reached", done, 1'b1);
    check("R10 R11 edge flag follows captured family", pos_edge_mode, fb);
    repeat (12) @(negedge clk);
    check("R9 done held, outputs quiet",
          {done, out_en_n, sh_clk, latch, col_data}, {4'b1000, 6'h00});
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; fam_b_sel = 1'b0; half_div = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs",
          {sh_clk, latch, col_data, done, pos_edge_mode, out_en_n}, {10'b0, 1'b1});
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {sh_clk, latch, done, out_en_n}, 4'b0001);

    run_seq(1'b0, 4'd0, 0);
    run_seq(1'b1, 4'd2, 0);
    run_seq(1'b1, 4'd1, 25);
    run_seq(1'b0, 4'd3, 40);
    for (int k = 0; k < 5; k++) begin
      logic fb;
      logic [DW-1:0] dv;
      int pk;
      fb = 1'($urandom % 2);
      dv = DW'($urandom % 4);
      pk = ($urandom % 2) ? int'($urandom % 200) + 1 : 0;
      run_seq(fb, dv, pk);
    end

    $display("Simulation finished: %0d checks, %0d errors", t_chk + m_chk, t_err + m_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", t_chk + m_chk + 1, t_err + m_err + 1);
    $finish;
  end

endmodule